// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Controller

This block gathers the event pulses raised by the transmit and receive halves of an Ethernet DMA engine and holds each one as a sticky status bit. Software reads the status word over a simple 32-bit register port and clears bits by writing ones to them. The status word also carries the current transmit and receive process-state codes as read-only fields.

The events fall into two fixed groups. The normal group covers completion and buffer-availability events. The abnormal group covers stop, error and timeout events. Each group produces a summary bit. A group member adds to its summary only while its own enable bit is set. A single level interrupt line is raised when an enabled summary is active. Two register addresses are decoded: `reg_sel = 0` selects the status word and `reg_sel = 1` selects the interrupt-enable word. Reads are combinational and have no side effects.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[i]` sets status bit i at the next rising edge. This applies to i in {0..10, 13, 14}. The bit meanings are: 0 tx done, 1 tx stopped, 2 tx buffer unavailable, 3 jabber timeout, 4 rx overflow, 5 tx underflow, 6 rx done, 7 rx buffer unavailable, 8 rx stopped, 9 rx watchdog, 10 early tx, 13 fatal bus error, 14 early rx.
- R2: A status bit stays set until a write to address 0 carries a one in its position. Zeros in the write data leave bits unchanged. The clearable region is mask 0x0001E7FF.
- R3: When an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R4: Status bits 11 and 12 always read zero. Pulses on `evt_pulse[11]` and `evt_pulse[12]` are ignored.
- R5: Status bit 16 (normal summary) is the OR of status bits 0, 2, 6 and 14, each gated by the enable bit at the same position.
- R6: Status bit 15 (abnormal summary) is the OR of status bits 1, 3, 4, 5, 7, 8, 9, 10 and 13, each gated by the enable bit at the same position. The summary enables at bits 16 and 15 do not affect the summary bits themselves.
- R7: Status bits 22:20 report `tx_state` and bits 19:17 report `rx_state`, each registered one cycle. Both fields reset to 000 (stopped). Writes to bits 31:17 of the status word have no effect, and bits 31:23 read zero.
- R8: The enable word at address 1 keeps bits 0–10 and 13–16 as written and reads zero in every other bit. Bit 16 enables the normal summary and bit 15 enables the abnormal summary.
- R9: `irq` is a register. It equals (normal summary AND enable bit 16) OR (abnormal summary AND enable bit 15), evaluated on the previous cycle's status and enables.
- R10: After reset, the status word, the enable word and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 status, 1 interrupt enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Live read data of the selected register |
| evt_pulse | input | 15 | Event pulses, one per status position |
| tx_state | input | 3 | Current transmit process state code |
| rx_state | input | 3 | Current receive process state code |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives an event pulse and a clearing write to the same bit in one cycle. A design that gives the clear priority would lose the event and read the bit as zero. It enables a group member without its summary enable, and the reverse, to catch a design that ignores one level of the two-level gating. Such a design would raise `irq` spuriously or hide a summary bit. It also checks that `irq` lags status by exactly one cycle, that writes to the state fields and to bits 11 and 12 leave them untouched, and that a cleared bit drops its summary.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int REG_W    = 32;
    localparam int EVT_W    = 15;
    localparam int ST_W     = 3;
    localparam int ASUM_POS = 15;
    localparam int NSUM_POS = 16;

    // Group membership over the event positions
    localparam logic [EVT_W-1:0] NORM_GRP = EVT_W'(15'h4045);
    localparam logic [EVT_W-1:0] ABN_GRP  = EVT_W'(15'h27BA);
    localparam logic [EVT_W-1:0] EVT_LIVE = NORM_GRP | ABN_GRP;

    // Bits of the enable word that hold storage
    localparam logic [REG_W-1:0] IEN_KEEP =
        {{(REG_W-NSUM_POS-1){1'b0}}, 2'b11, EVT_LIVE};

    typedef enum logic [ST_W-1:0] {
        TXS_STOP  = 3'b000,
        TXS_FETCH = 3'b001,
        TXS_WAIT  = 3'b010,
        TXS_READ  = 3'b011,
        TXS_SUSP  = 3'b110,
        TXS_CLOSE = 3'b111
    } tx_proc_e;

    typedef enum logic [ST_W-1:0] {
        RXS_STOP  = 3'b000,
        RXS_FETCH = 3'b001,
        RXS_WAIT  = 3'b011,
        RXS_SUSP  = 3'b100,
        RXS_CLOSE = 3'b101,
        RXS_XFER  = 3'b111
    } rx_proc_e;

    typedef struct packed {
        logic [REG_W-EVT_W-2-2*ST_W-1:0] rsvd;
        logic [ST_W-1:0]                 tx_st;
        logic [ST_W-1:0]                 rx_st;
        logic                            nsum;
        logic                            asum;
        logic [EVT_W-1:0]                evt;
    } status_view_t;

    function automatic logic grp_hit(input logic [EVT_W-1:0] st,
                                     input logic [EVT_W-1:0] en,
                                     input logic [EVT_W-1:0] grp);
        return |(st & en & grp);
    endfunction

endpackage

// File: rtl/dma_irq_status_bank.sv
module dma_irq_status_bank
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [EVT_W-1:0] clr_i,
    output logic [EVT_W-1:0] status_o
);
    logic [EVT_W-1:0] status_q;
    logic [EVT_W-1:0] evt_live;

    assign evt_live = evt_i & EVT_LIVE;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= ((status_q & ~clr_i) | evt_live) & EVT_LIVE;
    end

    assign status_o = status_q;

    // R2: bits not being cleared stay set
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i)));

    // R1 and R3: a live event always lands, even against a clear
    a_r3_event_wins: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((status_q & $past(evt_live)) == $past(evt_live)));

    // R2: a clear without an event drops the bit
    a_r2_clear_takes: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((status_q & $past(clr_i & ~evt_live)) == '0));

    // R4: unassigned positions never hold a one
    a_r4_holes_zero: assert property (@(posedge clk) disable iff (rst)
        (status_q & ~EVT_LIVE) == '0);

endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] status_i,
    input  logic [EVT_W-1:0] ien_i,
    input  logic             nsum_en_i,
    input  logic             asum_en_i,
    output logic             nsum_o,
    output logic             asum_o,
    output logic             irq_o
);
    logic irq_q;

    assign nsum_o = grp_hit(status_i, ien_i, NORM_GRP);
    assign asum_o = grp_hit(status_i, ien_i, ABN_GRP);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= (nsum_o & nsum_en_i) | (asum_o & asum_en_i);
    end

    assign irq_o = irq_q;

    // R5: normal summary only from a set normal-group bit
    a_r5_nsum_source: assert property (@(posedge clk) disable iff (rst)
        nsum_o |-> |(status_i & NORM_GRP));

    // R6: abnormal summary only from a set abnormal-group bit
    a_r6_asum_source: assert property (@(posedge clk) disable iff (rst)
        asum_o |-> |(status_i & ABN_GRP));

    // R9: with nothing enabled and pending, irq is low next cycle
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !(|(status_i & ien_i)) |=> !irq_o);

endmodule

// File: rtl/dma_irq_state_capture.sv
module dma_irq_state_capture
    import dma_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] tx_i,
    input  logic [ST_W-1:0] rx_i,
    output logic [ST_W-1:0] tx_o,
    output logic [ST_W-1:0] rx_o
);
    tx_proc_e tx_q;
    rx_proc_e rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= TXS_STOP;
            rx_q <= RXS_STOP;
        end else begin
            tx_q <= tx_proc_e'(tx_i);
            rx_q <= rx_proc_e'(rx_i);
        end
    end

    assign tx_o = tx_q;
    assign rx_o = rx_q;

    // R7: fields follow their inputs one cycle later
    a_r7_state_track: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (tx_o == $past(tx_i) && rx_o == $past(rx_i)));

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [EVT_W-1:0] evt_pulse,
    input  logic [ST_W-1:0]  tx_state,
    input  logic [ST_W-1:0]  rx_state,
    output logic             irq
);
    logic [REG_W-1:0] ien_q;
    logic [EVT_W-1:0] clr_bits;
    logic [EVT_W-1:0] status_w;
    logic [ST_W-1:0]  tx_w;
    logic [ST_W-1:0]  rx_w;
    logic             nsum_w;
    logic             asum_w;
    status_view_t     view;

    assign clr_bits = (reg_wr && !reg_sel) ? (reg_wdata[EVT_W-1:0] & EVT_LIVE) : '0;

    always_ff @(posedge clk) begin
        if (rst)                  ien_q <= '0;
        else if (reg_wr && reg_sel) ien_q <= reg_wdata & IEN_KEEP;
    end

    dma_irq_status_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_pulse),
        .clr_i    (clr_bits),
        .status_o (status_w)
    );

    dma_irq_summary u_sum (
        .clk       (clk),
        .rst       (rst),
        .status_i  (status_w),
        .ien_i     (ien_q[EVT_W-1:0]),
        .nsum_en_i (ien_q[NSUM_POS]),
        .asum_en_i (ien_q[ASUM_POS]),
        .nsum_o    (nsum_w),
        .asum_o    (asum_w),
        .irq_o     (irq)
    );

    dma_irq_state_capture u_state (
        .clk  (clk),
        .rst  (rst),
        .tx_i (tx_state),
        .rx_i (rx_state),
        .tx_o (tx_w),
        .rx_o (rx_w)
    );

    always_comb begin
        view       = '0;
        view.tx_st = tx_w;
        view.rx_st = rx_w;
        view.nsum  = nsum_w;
        view.asum  = asum_w;
        view.evt   = status_w;
    end

    assign reg_rdata = reg_sel ? ien_q : view;

    // R8: enable word never stores outside its kept bits
    a_r8_ien_mask: assert property (@(posedge clk) disable iff (rst)
        (ien_q & ~IEN_KEEP) == '0);

    // R10: everything is clear in the first cycle after reset
    a_r10_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (status_w == '0 && ien_q == '0 && !irq));

endmodule

// File: tb/dma_irq_ctrl_tb.sv
module dma_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [14:0] evt_pulse = '0;
    logic [2:0]  tx_state = '0;
    logic [2:0]  rx_state = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dma_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .tx_state(tx_state), .rx_state(rx_state), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One cycle of stimulus, launched at a falling edge; returns at the next falling edge
    task automatic step(input logic [14:0] ev, input logic wr, input logic sel, input logic [31:0] d);
        @(negedge clk);
        evt_pulse = ev; reg_wr = wr; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic clear_all();
        step('0, 1'b1, 1'b0, 32'h0001E7FF);
        step('0, 1'b1, 1'b1, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(1'b0, v); chk("R10 status", v, 32'h0);
        rd(1'b1, v); chk("R10 enable", v, 32'h0);
        chk("R10 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_events();
        logic [31:0] v;
        step(15'h7FFF, 1'b0, 1'b0, '0);
        rd(1'b0, v);
        chk("R1 all events, R4 holes zero", v, 32'h000067FF);
        step('0, 1'b1, 1'b0, 32'h0);
        rd(1'b0, v); chk("R2 zero write keeps", v, 32'h000067FF);
        step('0, 1'b1, 1'b0, 32'h00000001);
        rd(1'b0, v); chk("R2 clear bit 0 only", v, 32'h000067FE);
        step('0, 1'b1, 1'b0, 32'h0001E7FF);
        rd(1'b0, v); chk("R2 clear all", v, 32'h0);
        step(15'h1800, 1'b0, 1'b0, '0);
        rd(1'b0, v); chk("R4 pulses on 11 and 12 ignored", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        step(15'h0040, 1'b0, 1'b0, '0);
        step(15'h0040, 1'b1, 1'b0, 32'h00000040);
        rd(1'b0, v); chk("R3 event beats clear", v, 32'h00000040);
        step(15'h0008, 1'b1, 1'b0, 32'h00000040);
        rd(1'b0, v); chk("R3 clear one bit while other sets", v, 32'h00000008);
        clear_all();
    endtask

    task automatic t_enable();
        logic [31:0] v;
        step('0, 1'b1, 1'b1, 32'hFFFFFFFF);
        rd(1'b1, v); chk("R8 enable readback mask", v, 32'h0001E7FF);
        step('0, 1'b1, 1'b1, 32'h00012345);
        rd(1'b1, v); chk("R8 enable pattern", v, 32'h00012345 & 32'h0001E7FF);
        clear_all();
    endtask

    task automatic t_normal();
        logic [31:0] v;
        step('0, 1'b1, 1'b1, 32'h00010001);
        step(15'h0004, 1'b0, 1'b0, '0);
        rd(1'b0, v); chk("R5 member without enable", v, 32'h00000004);
        @(negedge clk);
        chk("R9 no irq for ungated member", {31'b0, irq}, 32'h0);
        step(15'h0001, 1'b0, 1'b0, '0);
        rd(1'b0, v); chk("R5 normal summary set", v, 32'h00010005);
        chk("R9 irq one cycle later, still low", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq rises", {31'b0, irq}, 32'h1);
        step('0, 1'b1, 1'b0, 32'h00000001);
        rd(1'b0, v); chk("R5 summary drops with bit", v, 32'h00000004);
        @(negedge clk);
        chk("R9 irq falls", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_abnormal();
        logic [31:0] v;
        step('0, 1'b1, 1'b1, 32'h0000A000);
        step(15'h2010, 1'b0, 1'b0, '0);
        rd(1'b0, v); chk("R6 abnormal summary", v, 32'h0000A010);
        @(negedge clk);
        chk("R9 abnormal irq", {31'b0, irq}, 32'h1);
        step('0, 1'b1, 1'b1, 32'h00002000);
        rd(1'b0, v); chk("R6 summary independent of its enable", v, 32'h0000A010);
        @(negedge clk);
        chk("R9 irq off when summary disabled", {31'b0, irq}, 32'h0);
        step('0, 1'b1, 1'b1, 32'h00018001);
        rd(1'b0, v); chk("R6 abnormal member gated off", v, 32'h00002010);
        @(negedge clk);
        chk("R9 no irq from wrong group", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_state();
        logic [31:0] v;
        @(negedge clk);
        tx_state = 3'b110; rx_state = 3'b101;
        @(negedge clk);
        rd(1'b0, v); chk("R7 suspended tx, closing rx", v, 32'h006A0000);
        step('0, 1'b1, 1'b0, 32'hFFFE0000);
        rd(1'b0, v); chk("R7 state field write ignored", v, 32'h006A0000);
        tx_state = 3'b011; rx_state = 3'b111;
        @(negedge clk);
        rd(1'b0, v); chk("R7 reading tx, transferring rx", v, 32'h003E0000);
        tx_state = 3'b000; rx_state = 3'b000;
        @(negedge clk);
        rd(1'b0, v); chk("R7 back to stopped", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_events();
        t_collide();
        t_enable();
        t_normal();
        t_abnormal();
        t_state();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule